// File: doc/BRIEF.md
# Four-bit ECC correction sequencer

This block runs the correction step for one 512-byte sector after the sector has been read. A separate syndrome and error-locator engine does the arithmetic. The sequencer supplies that engine with the stored check code and then applies whatever repairs the engine reports.

A start pulse carries ten stored check bytes. The sequencer turns them into eight 10-bit codes and loads them into the engine. It then reads the four syndrome words. If every syndrome is zero, it finishes with nothing to do. Otherwise it clears the locator, starts it, and waits for a trustworthy final state. For each located error it fetches the address and value. It converts the address into a byte offset and repairs the sector buffer with a read-modify-write.

One result is reported per run, marked by a single-cycle done pulse. The result is either the number of bytes repaired or an uncorrectable flag.

Engine register selects on `eng_rsel`:

| Select | Register |
|--------|----------|
| 0 to 3 | Syndrome words |
| 4 | Status |
| 5 | Address pair A |
| 6 | Address pair B |
| 7 | Value pair A |
| 8 | Value pair B |

`eng_rdata` is sampled at the clock edge on which `eng_rd` is high.

Top module: `ecc4_fix_seq`

## Requirements
- R1: Check byte k sits at `ecc_bytes[8k+7:8k]`. Code i is bits `[10i+9:10i]` of the resulting 80-bit little-endian stream. All eight codes are captured at start, before any load write.
- R2: After start, the eight codes are written through `eng_wr`/`eng_wdata` on eight consecutive cycles, code 7 first and code 0 last.
- R3: Syndrome selects 0 to 3 are read, and each is masked with 0x03FF03FF. If all four masked words are zero, the run ends with count 0, no uncorrectable flag, and no `eng_calc_start`.
- R4: The cycle just before the single-cycle `eng_calc_start` pulse is a read of select 5, which clears any earlier calculation.
- R5: The engine state is status bits [11:8]. During the first wait phase, any state below 4 is ignored, for at most WAIT_LIMIT status reads. After that phase ends, either because a busy value was seen or because the limit expired, polling continues and the final states of R6 are honoured.
- R6: After the first wait phase, the final states are decoded as follows:
  - State 0 ends the run with count 0.
  - State 1 ends the run with the uncorrectable flag.
  - State 2 or 3 gives an error count of status bits [17:16] plus 1.
  - Any state of 4 or above keeps the sequencer polling.
- R7: The register pair used depends on the error number:
  - Errors 0 and 1 take their address from select 5 and their value from select 7.
  - Errors 2 and 3 take their address from select 6 and their value from select 8.
  - Odd errors use bits [25:16] of the word and even errors use bits [9:0].
  - The low 8 bits of the value are XORed into the byte.
- R8: The byte offset is 519 minus the 10-bit address. Only offsets 0 to 511 are repaired; all other offsets are skipped without touching the buffer. A repair reads the byte, then writes the byte XOR the value in the next cycle. Buffer read data arrives one cycle after `buf_rd`.
- R9: `done` is high for exactly one cycle per run. `err_count` holds the number of bytes actually repaired, and `uncorrectable` marks the state-1 outcome, in which case the count is 0.
- R10: During and straight after reset, `done`, `eng_wr`, `eng_rd`, `eng_calc_start`, `buf_rd` and `buf_wr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a correction run (accepted when idle) |
| ecc_bytes | input | 80 | Ten stored check bytes, byte 0 in the low bits |
| eng_wr | output | 1 | Load-port write strobe |
| eng_wdata | output | 10 | Code written to the load port |
| eng_rd | output | 1 | Engine register read strobe |
| eng_rsel | output | 4 | Engine register select |
| eng_rdata | input | 32 | Engine register read data |
| eng_calc_start | output | 1 | Start error-address calculation |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, one cycle after `buf_rd` |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Repaired byte |
| done | output | 1 | Single-cycle completion pulse |
| err_count | output | 3 | Bytes repaired in the last run |
| uncorrectable | output | 1 | Last run could not be corrected |

## Verification
The assertions check the following on every cycle:
- `done` is a pulse, and the uncorrectable outcome never carries a count.
- Every buffer write follows a read at the same address.
- The calculation start is always immediately preceded by the clearing read.

Only the bench scenarios can show the rest:
- the load order and unpacking;
- the effect of the syndrome mask;
- that an early state of 3 is ignored until busy is seen or the wait limit runs out;
- that reverse-indexed addresses pointing into the check bytes are skipped;
- the buffer contents after each repair.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  localparam logic [3:0] SEL_SYN0   = 4'd0;
  localparam logic [3:0] SEL_STAT   = 4'd4;
  localparam logic [3:0] SEL_ADDR_A = 4'd5;
  localparam logic [3:0] SEL_ADDR_B = 4'd6;
  localparam logic [3:0] SEL_VAL_A  = 4'd7;
  localparam logic [3:0] SEL_VAL_B  = 4'd8;
  localparam logic [31:0] SYN_MASK  = 32'h03FF03FF;
  localparam int STATE_LSB = 8;
  localparam int CNT_LSB   = 16;
  localparam int HALF_LSB  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SYN, S_CHECK, S_DUMMY, S_KICK, S_WAIT, S_POLL,
    S_GETA, S_GETV, S_RMWR, S_RMWW, S_NEXT, S_DONE
  } seq_state_t;
endpackage

// File: rtl/ecc4_unpack.sv
module ecc4_unpack #(
  parameter int CODE_W  = 10,
  parameter int N_CODES = 8,
  localparam int IN_W   = CODE_W * N_CODES
) (
  input  logic [IN_W-1:0]                  packed_in,
  output logic [N_CODES-1:0][CODE_W-1:0]   codes
);
  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    assign codes[g] = packed_in[g*CODE_W +: CODE_W];
  end
endmodule

// File: rtl/ecc4_locate.sv
module ecc4_locate #(
  parameter int CODE_W       = 10,
  parameter int SECTOR_BYTES = 512,
  parameter int TAIL_BYTES   = 7,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int BIAS        = SECTOR_BYTES + TAIL_BYTES,
  localparam int DW          = CODE_W + 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [OFF_W-1:0]  offset,
  output logic              in_range
);
  logic signed [DW-1:0] diff;
  assign diff     = $signed(DW'(BIAS)) - $signed({2'b00, code});
  assign in_range = !diff[DW-1] && (diff < $signed(DW'(SECTOR_BYTES)));
  assign offset   = diff[OFF_W-1:0];
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int N_CODES      = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int TAIL_BYTES   = 7,
  parameter int WAIT_LIMIT   = 32,
  localparam int IN_W        = CODE_W * N_CODES,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int TMR_W       = $clog2(WAIT_LIMIT + 1),
  localparam int IDX_W       = $clog2(N_CODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IN_W-1:0]   ecc_bytes,
  output logic              eng_wr,
  output logic [CODE_W-1:0] eng_wdata,
  output logic              eng_rd,
  output logic [3:0]        eng_rsel,
  input  logic [31:0]       eng_rdata,
  output logic              eng_calc_start,
  output logic [OFF_W-1:0]  buf_addr,
  output logic              buf_rd,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr,
  output logic [7:0]        buf_wdata,
  output logic              done,
  output logic [2:0]        err_count,
  output logic              uncorrectable
);
  seq_state_t st;
  logic [N_CODES-1:0][CODE_W-1:0] codes_w, codes_q;
  logic [IDX_W-1:0] idx;
  logic             syn_any;
  logic [TMR_W-1:0] timer;
  logic [2:0]       n_err;
  logic [1:0]       eidx;
  logic [CODE_W-1:0] addr_q;
  logic [7:0]       val_q;
  logic [OFF_W-1:0] off_q;
  logic [2:0]       cnt;
  logic             unc_f;
  logic [OFF_W-1:0] loc_off;
  logic             loc_ok;
  logic [3:0]       eng_state;
  logic [CODE_W-1:0] half;

  ecc4_unpack #(.CODE_W(CODE_W), .N_CODES(N_CODES)) u_unpack (
    .packed_in(ecc_bytes), .codes(codes_w));

  ecc4_locate #(.CODE_W(CODE_W), .SECTOR_BYTES(SECTOR_BYTES),
                .TAIL_BYTES(TAIL_BYTES)) u_locate (
    .code(addr_q), .offset(loc_off), .in_range(loc_ok));

  assign eng_state = eng_rdata[STATE_LSB +: 4];
  assign half      = eidx[0] ? eng_rdata[HALF_LSB +: CODE_W] : eng_rdata[0 +: CODE_W];

  always_comb begin
    eng_wr         = (st == S_LOAD);
    eng_wdata      = codes_q[idx];
    eng_calc_start = (st == S_KICK);
    eng_rd         = 1'b0;
    eng_rsel       = SEL_STAT;
    case (st)
      S_SYN:   begin eng_rd = 1'b1; eng_rsel = SEL_SYN0 + 4'(idx[1:0]); end
      S_DUMMY: begin eng_rd = 1'b1; eng_rsel = SEL_ADDR_A; end
      S_WAIT, S_POLL: eng_rd = 1'b1;
      S_GETA:  begin eng_rd = 1'b1; eng_rsel = eidx[1] ? SEL_ADDR_B : SEL_ADDR_A; end
      S_GETV:  begin eng_rd = 1'b1; eng_rsel = eidx[1] ? SEL_VAL_B : SEL_VAL_A; end
      default: ;
    endcase
    buf_addr  = off_q;
    buf_rd    = (st == S_RMWR);
    buf_wr    = (st == S_RMWW);
    buf_wdata = buf_rdata ^ val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; codes_q <= '0; idx <= '0; syn_any <= 1'b0; timer <= '0;
      n_err <= '0; eidx <= '0; addr_q <= '0; val_q <= '0; off_q <= '0;
      cnt <= '0; unc_f <= 1'b0; done <= 1'b0; err_count <= '0;
      uncorrectable <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          codes_q <= codes_w;
          idx     <= IDX_W'(N_CODES - 1);
          syn_any <= 1'b0; cnt <= '0; unc_f <= 1'b0; timer <= '0;
          st      <= S_LOAD;
        end
        S_LOAD: if (idx == '0) st <= S_SYN; else idx <= idx - 1'b1;
        S_SYN: begin
          syn_any <= syn_any | (|(eng_rdata & SYN_MASK));
          idx     <= idx + 1'b1;
          if (idx[1:0] == 2'd3) st <= S_CHECK;
        end
        S_CHECK: st <= syn_any ? S_DUMMY : S_DONE;
        S_DUMMY: st <= S_KICK;
        S_KICK:  st <= S_WAIT;
        S_WAIT: begin
          if (eng_state >= 4'd4 || timer == TMR_W'(WAIT_LIMIT - 1)) st <= S_POLL;
          else timer <= timer + 1'b1;
        end
        S_POLL: begin
          case (eng_state)
            4'd0: st <= S_DONE;
            4'd1: begin unc_f <= 1'b1; st <= S_DONE; end
            4'd2, 4'd3: begin
              n_err <= 3'(eng_rdata[CNT_LSB +: 2]) + 3'd1;
              eidx  <= '0;
              st    <= S_GETA;
            end
            default: st <= S_POLL;
          endcase
        end
        S_GETA: begin addr_q <= half; st <= S_GETV; end
        S_GETV: begin
          val_q <= half[7:0];
          off_q <= loc_off;
          st    <= loc_ok ? S_RMWR : S_NEXT;
        end
        S_RMWR: st <= S_RMWW;
        S_RMWW: begin cnt <= cnt + 1'b1; st <= S_NEXT; end
        S_NEXT: begin
          if ({1'b0, eidx} + 3'd1 == n_err) st <= S_DONE;
          else begin eidx <= eidx + 1'b1; st <= S_GETA; end
        end
        S_DONE: begin
          done <= 1'b1; err_count <= cnt; uncorrectable <= unc_f;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc4_fix_seq_chk.sv
module ecc4_fix_seq_chk
  import ecc4_pkg::*;
#(
  parameter int OFF_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_rd,
  input logic [3:0]       eng_rsel,
  input logic             eng_calc_start,
  input logic             eng_wr,
  input logic [OFF_W-1:0] buf_addr,
  input logic             buf_rd,
  input logic             buf_wr,
  input logic             done,
  input logic [2:0]       err_count,
  input logic             uncorrectable
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_UNC_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> (err_count == 3'd0)); // R9
  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_count <= 3'd4)); // R9
  AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    buf_wr |-> ($past(buf_rd) && $stable(buf_addr))); // R8
  AST_CLEAR_BEFORE_KICK: assert property (@(posedge clk) disable iff (rst)
    eng_calc_start |-> ($past(eng_rd) && $past(eng_rsel) == SEL_ADDR_A)); // R4
  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_calc_start |=> !eng_calc_start); // R4
  AST_LOAD_NOT_READ: assert property (@(posedge clk) disable iff (rst)
    eng_wr |-> !eng_rd); // R2
endmodule

bind ecc4_fix_seq ecc4_fix_seq_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/ecc4_fix_seq_tb.sv
`timescale 1ns/1ps
module ecc4_fix_seq_tb;
  localparam int WAIT_LIMIT = 32;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [79:0] ecc_bytes = '0;
  logic eng_wr, eng_rd, eng_calc_start, buf_rd, buf_wr, done, uncorrectable;
  logic [9:0] eng_wdata;
  logic [3:0] eng_rsel;
  logic [31:0] eng_rdata;
  logic [8:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata;
  logic [2:0] err_count;

  always #10 clk = ~clk;

  ecc4_fix_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .ecc_bytes(ecc_bytes),
    .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd), .eng_rsel(eng_rsel),
    .eng_rdata(eng_rdata), .eng_calc_start(eng_calc_start), .buf_addr(buf_addr),
    .buf_rd(buf_rd), .buf_rdata(buf_rdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .done(done), .err_count(err_count), .uncorrectable(uncorrectable));

  int n_chk = 0, n_fail = 0;
  int cycles = 0;

  // engine model configuration
  logic [31:0] syn [4];
  logic [31:0] addr_a, addr_b, val_a, val_b;
  int t3, tbusy, fstate, fcnt;
  int tcalc = 0;
  logic [9:0] ld_log [8];
  int ld_n = 0;
  bit calc_seen = 0, dummy_flag = 0, dummy_ok = 0, clr = 0;
  int done_n = 0;
  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  logic [7:0] eb [10];

  function automatic logic [31:0] stat_word();
    int s;
    s = (tcalc < t3) ? 3 : (tcalc < t3 + tbusy) ? 8 : fstate;
    return {14'd0, 2'(fcnt), 4'd0, 4'(s), 8'd0};
  endfunction

  always_comb begin
    case (eng_rsel)
      4'd0: eng_rdata = syn[0];
      4'd1: eng_rdata = syn[1];
      4'd2: eng_rdata = syn[2];
      4'd3: eng_rdata = syn[3];
      4'd4: eng_rdata = stat_word();
      4'd5: eng_rdata = addr_a;
      4'd6: eng_rdata = addr_b;
      4'd7: eng_rdata = val_a;
      4'd8: eng_rdata = val_b;
      default: eng_rdata = 32'd0;
    endcase
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) done_n <= done_n + 1;
    if (clr) begin
      ld_n <= 0; calc_seen <= 0; dummy_flag <= 0; dummy_ok <= 0; tcalc <= 0;
    end else begin
      if (eng_wr) begin
        if (ld_n < 8) ld_log[ld_n] <= eng_wdata;
        ld_n <= ld_n + 1;
      end
      if (eng_rd && eng_rsel == 4'd5) dummy_flag <= 1;
      if (eng_calc_start) begin
        calc_seen <= 1; dummy_ok <= dummy_flag; tcalc <= 0;
      end else tcalc <= tcalc + 1;
    end
    if (buf_rd) buf_rdata <= mem[buf_addr];
    if (buf_wr) mem[buf_addr] <= buf_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    check(0, "watchdog", cycles, 0);
    finish_run();
  end

  function automatic logic [9:0] ref_code(input int i);
    logic [9:0] c;
    for (int b = 0; b < 10; b++) begin
      int p;
      p = 10 * i + b;
      c[b] = eb[p / 8][p % 8];
    end
    return c;
  endfunction

  task automatic run(input int seed);
    bit clean, got;
    int exp_cnt, exp_unc, mism, first_bad;
    // prepare buffer, ecc bytes, expectations
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 7 + seed * 13 + 3) & 255);
      ref_mem[i] = mem[i];
    end
    for (int b = 0; b < 10; b++) begin
      eb[b] = 8'((seed * 29 + b * 53 + 1) & 255);
      ecc_bytes[8*b +: 8] = eb[b];
    end
    clean = ((syn[0] | syn[1] | syn[2] | syn[3]) & 32'h03FF03FF) == 0;
    exp_cnt = 0; exp_unc = 0;
    if (!clean) begin
      int eff;
      eff = (t3 >= WAIT_LIMIT) ? 3 : fstate;
      if (eff == 1) exp_unc = 1;
      else if (eff >= 2) begin
        for (int e = 0; e <= fcnt; e++) begin
          logic [31:0] aw, vw;
          int ad, off;
          aw = (e < 2) ? addr_a : addr_b;
          vw = (e < 2) ? val_a : val_b;
          ad = (e % 2 == 1) ? int'(aw[25:16]) : int'(aw[9:0]);
          off = 519 - ad;
          if (off >= 0 && off < 512) begin
            ref_mem[off] ^= ((e % 2 == 1) ? vw[23:16] : vw[7:0]);
            exp_cnt++;
          end
        end
      end
    end
    @(posedge clk); #1 clr = 1; done_n = 0;
    @(posedge clk); #1 clr = 0; start = 1;
    @(posedge clk); #1 start = 0;
    got = 0;
    for (int c = 0; c < 4000 && !got; c++) begin
      @(posedge clk); #1;
      if (done) got = 1;
    end
    check(got, "R9 done seen", int'(got), 1);
    check(int'(err_count) == exp_cnt, "R8 repaired count", err_count, exp_cnt);
    check(int'(uncorrectable) == exp_unc, "R6 uncorrectable", uncorrectable, exp_unc);
    repeat (3) @(posedge clk);
    #1;
    check(done_n == 1, "R9 single done pulse", done_n, 1);
    check(ld_n == 8, "R2 load count", ld_n, 8);
    for (int k = 0; k < 8; k++)
      check(ld_log[k] == ref_code(7 - k), "R1 R2 load order/unpack",
            ld_log[k], ref_code(7 - k));
    check(calc_seen == !clean, "R3 calc start iff syndrome", calc_seen, !clean);
    if (calc_seen) check(dummy_ok, "R4 clearing read before start", dummy_ok, 1);
    mism = 0; first_bad = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== ref_mem[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    check(mism == 0, "R7 R8 buffer contents (mismatch count/first)", mism, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) syn[i] = 0;
    addr_a = 0; addr_b = 0; val_a = 0; val_b = 0;
    t3 = 2; tbusy = 4; fstate = 0; fcnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check(!done && !eng_wr && !eng_rd && !eng_calc_start && !buf_rd && !buf_wr,
          "R10 reset outputs low", int'(done | eng_wr | eng_rd | buf_wr), 0);
    rst = 0;
    @(posedge clk); #1;
    check(!done && !eng_wr && !eng_rd && !buf_wr, "R10 idle after reset",
          int'(done | eng_wr | eng_rd | buf_wr), 0);

    // R3 clean sector
    run(1);
    // R3 syndrome bits only outside the mask are ignored
    syn[1] = 32'hFC00FC00; syn[3] = 32'h80008000;
    run(2);
    // single error at byte 100 (address 419), even half
    syn[1] = 32'h1; t3 = 3; tbusy = 5; fstate = 2; fcnt = 0;
    addr_a = 32'd419; val_a = 32'h5A;
    run(3);
    // R7 R8 four errors: offsets 0 and 511, one into check bytes, one beyond
    fstate = 3; fcnt = 3;
    addr_a = {6'd0, 10'd8, 6'd0, 10'd519};
    val_a  = {8'd0, 8'hC3, 8'd0, 8'h81};
    addr_b = {6'd0, 10'd700, 6'd0, 10'd3};
    val_b  = {8'd0, 8'h11, 8'd0, 8'h22};
    run(4);
    // R5 early state 3 ignored: true outcome is uncorrectable
    t3 = 3; tbusy = 5; fstate = 1; fcnt = 2;
    run(5);
    // R6 state 0 after busy: nothing repaired
    fstate = 0;
    run(6);
    // R5 timeout: state 3 throughout, accepted after the wait limit
    t3 = 1000000; tbusy = 0; fstate = 3; fcnt = 1;
    addr_a = {6'd0, 10'd300, 6'd0, 10'd10};
    val_a  = {8'd0, 8'h0F, 8'd0, 8'hF0};
    run(7);
    // R6 long busy beyond the wait limit, then ready
    t3 = 2; tbusy = 3 * WAIT_LIMIT; fstate = 2; fcnt = 2;
    addr_b = {6'd0, 10'd50, 6'd0, 10'd60};
    val_b  = {8'd0, 8'h33, 8'd0, 8'h44};
    run(8);
    // sweep of counts, halves and address ranges
    for (int k = 0; k < 24; k++) begin
      syn[0] = 32'((k * 97 + 5) & 32'h3FF); syn[1] = 0; syn[2] = 0; syn[3] = 0;
      t3 = k % 4; tbusy = 1 + k % 5; fstate = 2 + (k % 2); fcnt = k % 4;
      addr_a = {6'd0, 10'((8 + k * 37) % 1024), 6'd0, 10'((8 + k * 131) % 600)};
      addr_b = {6'd0, 10'((k * 53) % 530), 6'd0, 10'((519 - k * 11) % 1024)};
      val_a  = {8'd0, 8'(k * 3 + 1), 8'd0, 8'(k * 5 + 2)};
      val_b  = {8'd0, 8'(k * 7 + 3), 8'd0, 8'(k * 9 + 4)};
      run(10 + k);
    end
    finish_run();
  end
endmodule